// File: doc/BRIEF.md
# DMA Descriptor Chain Sequencer

This block steps one DMA channel through a linked list of command descriptors held in system memory. For each descriptor it reads the header words one at a time over a simple request/valid memory port. It decodes a two-bit command and delivers any programmed-I/O (PIO) words to the peripheral. It then starts a data phase on an external byte mover, if the command needs one. Last, it picks the address of the next descriptor.

A descriptor is a run of 32-bit words at consecutive word addresses. It holds the next-descriptor pointer at offset 0, a control word at offset 1, a buffer pointer at offset 2, and then the PIO words from offset 3 upward. The control word carries the command in bits [1:0], the chain flag in bit 2, the PIO word count in bits [4 +: PCW], and the byte count in bits [16 +: BCW]. The conditional-branch command lets the channel jump to an alternate list when the peripheral reports a true sense line. A second input tells the block whether the channel supports this branch at all.

States: `S_IDLE`, `S_GET_NEXT`, `S_GET_CTRL`, `S_GET_BUF`, `S_PIO_FETCH`, `S_PIO_ISSUE`, `S_XFER_GO`, `S_XFER_WAIT`, `S_ROUTE`.

Transitions:
- `S_IDLE` goes to `S_GET_NEXT` on start.
- The three GET states advance on `mem_rvalid`.
- `S_GET_BUF` goes to `S_PIO_FETCH` if the effective PIO count is non-zero. Otherwise it goes to `S_XFER_GO` for a transfer command, or to `S_ROUTE`.
- `S_PIO_FETCH` goes to `S_PIO_ISSUE` on `mem_rvalid`.
- `S_PIO_ISSUE` returns to `S_PIO_FETCH` on `periph_ready` while words remain. After the last word it moves to `S_XFER_GO` or `S_ROUTE`.
- `S_XFER_GO` goes to `S_XFER_WAIT`.
- `S_XFER_WAIT` goes to `S_ROUTE` on `xfer_done`.
- `S_ROUTE` goes to `S_GET_NEXT` when the list continues, otherwise to `S_IDLE`.

Top module: `dma_chain_seq`

## Requirements
- R1: A start pulse in idle makes the block read the words at `start_addr`, `start_addr+1` and `start_addr+2`. Each read holds `mem_req` with a stable `mem_addr` until `mem_rvalid`.
- R2: Command encodings are 00 no-transfer, 01 write (peripheral to memory), 10 read (memory to peripheral) and 11 sense-branch.
- R3: PIO words are read from descriptor offsets 3 upward. Each word is presented on `pio_data`, with `pio_idx` counting from 0 within the descriptor. It is held until `periph_ready` is high. A PIO count of zero skips the PIO phase.
- R4: A write command pulses `xfer_start` with `xfer_to_mem`=1, `xfer_addr` equal to the buffer pointer and `xfer_bytes` equal to the byte count. It then waits for `xfer_done`.
- R5: A read command pulses `xfer_start` with `xfer_to_mem`=0 and the same address and count fields.
- R6: The no-transfer and sense commands never pulse `xfer_start`.
- R7: For commands 00, 01 and 10, a set chain flag fetches the descriptor at the next pointer. A clear chain flag pulses `chain_done` for one cycle and returns to idle.
- R8: With `sense_capable` high, the sense command performs its PIO words and then samples `sense_in`. It continues at the buffer pointer when sense is true and at the next pointer when false. The chain flag is ignored.
- R9: With `sense_capable` low, the sense command is a no-operation: it writes no PIO words and follows the chain flag as in R7.
- R10: A start pulse while the block is busy is ignored.
- R11: In any cycle, at most one of `mem_req`, `pio_valid` and `xfer_start` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin walking a list (accepted only in idle) |
| start_addr | input | AW | Word address of the first descriptor |
| sense_capable | input | 1 | Channel supports the sense branch |
| sense_in | input | 1 | Peripheral sense line |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | AW | Word address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| pio_valid | output | 1 | PIO word offered to the peripheral |
| pio_idx | output | PCW | Index of the PIO word within the descriptor |
| pio_data | output | 32 | PIO word |
| periph_ready | input | 1 | Peripheral accepts the PIO word |
| xfer_start | output | 1 | One-cycle data-phase start to the mover |
| xfer_to_mem | output | 1 | 1: peripheral to memory, 0: memory to peripheral |
| xfer_addr | output | AW | Buffer pointer for the data phase |
| xfer_bytes | output | BCW | Byte count for the data phase |
| xfer_done | input | 1 | Mover finished the data phase |
| chain_done | output | 1 | One-cycle pulse when the list ends |
| busy | output | 1 | Sequencer is not idle |

## Verification
Assertions check several properties on every cycle:
- the memory request and the PIO offer stay stable while stalled;
- the three output phases are exclusive;
- a list end always lands in idle;
- busy falls only through a list end;
- a data start happens only for a transfer command.

Only the bench scenarios show the rest: the order and values of PIO words, the transfer fields, and which pointer a branch follows. The bench sweeps every combination of sense, capability and chain flag, and PIO counts 0 to 4 under both transfer directions, with and without peripheral stalls.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    localparam int DW          = 32;
    localparam int CHAIN_BIT   = 2;
    localparam int PIO_LSB     = 4;
    localparam int BYTES_LSB   = 16;
    localparam int PIO_OFFSET  = 3;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_WR    = 2'b01,
        CMD_RD    = 2'b10,
        CMD_SENSE = 2'b11
    } dcs_cmd_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_GET_NEXT,
        S_GET_CTRL,
        S_GET_BUF,
        S_PIO_FETCH,
        S_PIO_ISSUE,
        S_XFER_GO,
        S_XFER_WAIT,
        S_ROUTE
    } dcs_state_e;
endpackage

// File: rtl/dcs_pio_count.sv
module dcs_pio_count #(
    parameter int PCW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [PCW-1:0] load_val,
    input  logic           step,
    output logic [PCW-1:0] idx,
    output logic           last
);
    logic [PCW-1:0] remain_q;
    logic [PCW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            idx_q    <= '0;
        end else if (load) begin
            remain_q <= load_val;
            idx_q    <= '0;
        end else if (step) begin
            remain_q <= remain_q - 1'b1;
            idx_q    <= idx_q + 1'b1;
        end
    end

    assign idx  = idx_q;
    assign last = (remain_q == PCW'(1));
endmodule

// File: rtl/dcs_next_sel.sv
module dcs_next_sel
    import dcs_pkg::*;
#(
    parameter int AW = 16
) (
    input  dcs_cmd_e        cmd,
    input  logic            chain,
    input  logic            sense_capable,
    input  logic            sense_in,
    input  logic [AW-1:0]   next_ptr,
    input  logic [AW-1:0]   buf_ptr,
    output logic            proceed,
    output logic [AW-1:0]   target
);
    always_comb begin
        if (cmd == CMD_SENSE && sense_capable) begin
            proceed = 1'b1;
            target  = sense_in ? buf_ptr : next_ptr;
        end else begin
            proceed = chain;
            target  = next_ptr;
        end
    end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
    import dcs_pkg::*;
#(
    parameter int AW  = 16,
    parameter int PCW = 4,
    parameter int BCW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   start_addr,
    input  logic            sense_capable,
    input  logic            sense_in,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_rvalid,
    input  logic [DW-1:0]   mem_rdata,
    output logic            pio_valid,
    output logic [PCW-1:0]  pio_idx,
    output logic [DW-1:0]   pio_data,
    input  logic            periph_ready,
    output logic            xfer_start,
    output logic            xfer_to_mem,
    output logic [AW-1:0]   xfer_addr,
    output logic [BCW-1:0]  xfer_bytes,
    input  logic            xfer_done,
    output logic            chain_done,
    output logic            busy
);
    localparam logic [AW-1:0] OFS_CTRL = AW'(1);
    localparam logic [AW-1:0] OFS_BUF  = AW'(2);
    localparam logic [AW-1:0] OFS_PIO  = AW'(PIO_OFFSET);

    dcs_state_e state_q, state_d;

    logic [AW-1:0]  cur_q, next_q, buf_q;
    dcs_cmd_e       cmd_q;
    logic           chain_q;
    logic [PCW-1:0] pcnt_q;
    logic [BCW-1:0] bytes_q;
    logic [DW-1:0]  pio_q;

    logic           pc_load, pc_step, pc_last;
    logic [PCW-1:0] pc_idx;
    logic           proceed;
    logic [AW-1:0]  target;
    logic           has_xfer;
    logic [PCW-1:0] pio_eff;

    assign has_xfer = (cmd_q == CMD_WR) || (cmd_q == CMD_RD);
    assign pio_eff  = (cmd_q == CMD_SENSE && !sense_capable) ? '0 : pcnt_q;
    assign pc_load  = (state_q == S_GET_BUF) && mem_rvalid;
    assign pc_step  = (state_q == S_PIO_ISSUE) && periph_ready;

    dcs_pio_count #(.PCW(PCW)) u_pcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pc_load),
        .load_val (pio_eff),
        .step     (pc_step),
        .idx      (pc_idx),
        .last     (pc_last)
    );

    dcs_next_sel #(.AW(AW)) u_nsel (
        .cmd           (cmd_q),
        .chain         (chain_q),
        .sense_capable (sense_capable),
        .sense_in      (sense_in),
        .next_ptr      (next_q),
        .buf_ptr       (buf_q),
        .proceed       (proceed),
        .target        (target)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start) state_d = S_GET_NEXT;
            S_GET_NEXT:  if (mem_rvalid) state_d = S_GET_CTRL;
            S_GET_CTRL:  if (mem_rvalid) state_d = S_GET_BUF;
            S_GET_BUF:
                if (mem_rvalid) begin
                    if (pio_eff != '0) state_d = S_PIO_FETCH;
                    else if (has_xfer) state_d = S_XFER_GO;
                    else               state_d = S_ROUTE;
                end
            S_PIO_FETCH: if (mem_rvalid) state_d = S_PIO_ISSUE;
            S_PIO_ISSUE:
                if (periph_ready) begin
                    if (!pc_last)      state_d = S_PIO_FETCH;
                    else if (has_xfer) state_d = S_XFER_GO;
                    else               state_d = S_ROUTE;
                end
            S_XFER_GO:   state_d = S_XFER_WAIT;
            S_XFER_WAIT: if (xfer_done) state_d = S_ROUTE;
            S_ROUTE:     state_d = proceed ? S_GET_NEXT : S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // descriptor capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= '0;
            next_q  <= '0;
            buf_q   <= '0;
            cmd_q   <= CMD_NONE;
            chain_q <= 1'b0;
            pcnt_q  <= '0;
            bytes_q <= '0;
            pio_q   <= '0;
        end else begin
            if (state_q == S_IDLE && start)
                cur_q <= start_addr;
            if (state_q == S_ROUTE && proceed)
                cur_q <= target;
            if (state_q == S_GET_NEXT && mem_rvalid)
                next_q <= mem_rdata[AW-1:0];
            if (state_q == S_GET_CTRL && mem_rvalid) begin
                cmd_q   <= dcs_cmd_e'(mem_rdata[1:0]);
                chain_q <= mem_rdata[CHAIN_BIT];
                pcnt_q  <= mem_rdata[PIO_LSB +: PCW];
                bytes_q <= mem_rdata[BYTES_LSB +: BCW];
            end
            if (state_q == S_GET_BUF && mem_rvalid)
                buf_q <= mem_rdata[AW-1:0];
            if (state_q == S_PIO_FETCH && mem_rvalid)
                pio_q <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_addr   = cur_q;
        pio_valid  = 1'b0;
        xfer_start = 1'b0;
        chain_done = 1'b0;
        unique case (state_q)
            S_GET_NEXT:  mem_req = 1'b1;
            S_GET_CTRL:  begin mem_req = 1'b1; mem_addr = cur_q + OFS_CTRL; end
            S_GET_BUF:   begin mem_req = 1'b1; mem_addr = cur_q + OFS_BUF; end
            S_PIO_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + OFS_PIO + {{(AW-PCW){1'b0}}, pc_idx};
            end
            S_PIO_ISSUE: pio_valid = 1'b1;
            S_XFER_GO:   xfer_start = 1'b1;
            S_ROUTE:     chain_done = !proceed;
            default:     ;
        endcase
    end

    assign busy        = (state_q != S_IDLE);
    assign pio_data    = pio_q;
    assign pio_idx     = pc_idx;
    assign xfer_to_mem = (cmd_q == CMD_WR);
    assign xfer_addr   = buf_q;
    assign xfer_bytes  = bytes_q;

    // checks next to the logic
    a_r11_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, pio_valid, xfer_start}));
    a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));
    a_r3_pio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pio_valid && !periph_ready |=> pio_valid && $stable(pio_data) && $stable(pio_idx));
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |=> !busy);
    a_r10_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !chain_done |=> busy);
    a_r6_xfer_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> (cmd_q == CMD_WR || cmd_q == CMD_RD));
endmodule

// File: tb/dma_chain_seq_tb_top.sv
`timescale 1ns/1ps
module dma_chain_seq_tb_top;
    localparam int AW = 16, PCW = 4, BCW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, sense_capable = 1'b0, sense_in = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic mem_req, mem_rvalid = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic pio_valid, periph_ready = 1'b1;
    logic [PCW-1:0] pio_idx;
    logic [31:0] pio_data;
    logic xfer_start, xfer_to_mem, xfer_done = 1'b0;
    logic [AW-1:0] xfer_addr;
    logic [BCW-1:0] xfer_bytes;
    logic chain_done, busy;

    always #2.5 clk = ~clk;

    dma_chain_seq #(.AW(AW), .PCW(PCW), .BCW(BCW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .sense_capable(sense_capable), .sense_in(sense_in),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .pio_valid(pio_valid), .pio_idx(pio_idx), .pio_data(pio_data), .periph_ready(periph_ready),
        .xfer_start(xfer_start), .xfer_to_mem(xfer_to_mem), .xfer_addr(xfer_addr),
        .xfer_bytes(xfer_bytes), .xfer_done(xfer_done), .chain_done(chain_done), .busy(busy)
    );

    logic [31:0] mem [0:63];
    int total = 0, fails = 0, cyc = 0;
    bit stall_mode = 0;
    int mv_cnt = 0;

    // memory responder
    always @(posedge clk) begin
        mem_rvalid <= mem_req && !mem_rvalid;
        mem_rdata  <= mem[mem_addr[5:0]];
    end
    // peripheral and mover models
    always @(posedge clk) begin
        cyc <= cyc + 1;
        periph_ready <= stall_mode ? ((cyc % 3) == 0) : 1'b1;
        if (xfer_start) mv_cnt <= 3;
        else if (mv_cnt != 0) mv_cnt <= mv_cnt - 1;
        xfer_done <= (mv_cnt == 1);
    end

    // logs
    logic [31:0] pio_log [0:15];
    int          idx_log [0:15];
    int pio_n = 0, xfer_n = 0, done_n = 0;
    logic        xd_log [0:3];
    logic [AW-1:0] xa_log [0:3];
    logic [BCW-1:0] xb_log [0:3];

    always @(negedge clk) begin
        if (pio_valid && periph_ready && pio_n < 16) begin
            pio_log[pio_n] = pio_data; idx_log[pio_n] = int'(pio_idx); pio_n++;
        end
        if (xfer_start && xfer_n < 4) begin
            xd_log[xfer_n] = xfer_to_mem; xa_log[xfer_n] = xfer_addr;
            xb_log[xfer_n] = xfer_bytes; xfer_n++;
        end
        if (chain_done) done_n++;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(input int cmd, input int chain, input int pio, input int bytes);
        return (32'(bytes) << 16) | (32'(pio) << 4) | (32'(chain) << 2) | 32'(cmd);
    endfunction

    task automatic clear_all();
        for (int i = 0; i < 64; i++) mem[i] = '0;
        pio_n = 0; xfer_n = 0; done_n = 0;
    endtask

    task automatic run_chain(input logic [AW-1:0] a, input bit extra);
        int t;
        @(negedge clk); start_addr = a; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (extra) begin
            repeat (6) @(negedge clk);
            start_addr = 16'd40; start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        t = 0;
        while (busy && t < 3000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        clear_all();
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !pio_valid && !xfer_start && !chain_done, "reset R1",
            {busy, mem_req, pio_valid, xfer_start, chain_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // three-descriptor list: R1 R3 R4 R5 R7 R10
        for (int s = 0; s < 2; s++) begin
            clear_all(); stall_mode = (s == 1);
            mem[0] = 10; mem[1] = ctl(1, 1, 2, 'h40); mem[2] = 'h100; mem[3] = 'h11; mem[4] = 'h22;
            mem[10] = 20; mem[11] = ctl(2, 1, 0, 8); mem[12] = 'h200;
            mem[20] = 30; mem[21] = ctl(0, 0, 3, 0); mem[22] = 0;
            mem[23] = 'h33; mem[24] = 'h44; mem[25] = 'h55;
            run_chain(0, 1);
            chk(pio_n == 5, "R3 pio count", pio_n, 5);
            chk(pio_log[0] == 'h11 && idx_log[0] == 0, "R3 pio0", pio_log[0], 'h11);
            chk(pio_log[1] == 'h22 && idx_log[1] == 1, "R3 pio1", pio_log[1], 'h22);
            chk(pio_log[2] == 'h33 && idx_log[2] == 0, "R3 pio2", pio_log[2], 'h33);
            chk(pio_log[4] == 'h55 && idx_log[4] == 2, "R3 pio4", pio_log[4], 'h55);
            chk(xfer_n == 2, "R6 xfer count", xfer_n, 2);
            chk(xd_log[0] == 1 && xa_log[0] == 'h100 && xb_log[0] == 'h40, "R4 write fields",
                {xd_log[0], xa_log[0], xb_log[0]}, {1'b1, 16'h100, 16'h40});
            chk(xd_log[1] == 0 && xa_log[1] == 'h200 && xb_log[1] == 8, "R5 read fields",
                {xd_log[1], xa_log[1], xb_log[1]}, {1'b0, 16'h200, 16'h8});
            chk(done_n == 1 && !busy, "R7 R10 single completion", done_n, 1);
        end
        stall_mode = 0;

        // PIO count sweep with both transfer directions: R2 R3 R4 R5
        for (int dir = 1; dir <= 2; dir++) begin
            for (int p = 0; p <= 4; p++) begin
                clear_all();
                mem[0] = 0; mem[1] = ctl(dir, 0, p, 4 * p + 1); mem[2] = 'h300 + p;
                for (int k = 0; k < p; k++) mem[3 + k] = 'h1000 * dir + 'h100 + k;
                run_chain(0, 0);
                chk(pio_n == p, "R3 pio sweep count", pio_n, p);
                for (int k = 0; k < p; k++)
                    chk(pio_log[k] == 32'('h1000 * dir + 'h100 + k) && idx_log[k] == k,
                        "R3 pio sweep word", pio_log[k], 'h1000 * dir + 'h100 + k);
                chk(xfer_n == 1 && xd_log[0] == (dir == 1) && xa_log[0] == AW'('h300 + p)
                    && xb_log[0] == BCW'(4 * p + 1), dir == 1 ? "R4 sweep xfer" : "R5 sweep xfer",
                    {xd_log[0], xa_log[0]}, {(dir == 1), 16'('h300 + p)});
                chk(done_n == 1, "R7 end on clear chain", done_n, 1);
            end
        end

        // sense sweep: R8 R9 R6
        for (int cap = 0; cap < 2; cap++)
            for (int sn = 0; sn < 2; sn++)
                for (int ch = 0; ch < 2; ch++) begin
                    int en; logic [31:0] e0, e1;
                    clear_all();
                    sense_capable = cap[0]; sense_in = sn[0];
                    mem[0] = 8; mem[1] = ctl(3, ch, 1, 'h20); mem[2] = 16; mem[3] = 'hA0;
                    mem[8] = 0; mem[9] = ctl(0, 0, 1, 0); mem[10] = 0; mem[11] = 'hB8;
                    mem[16] = 0; mem[17] = ctl(0, 0, 1, 0); mem[18] = 0; mem[19] = 'hC16;
                    if (cap == 1) begin en = 2; e0 = 'hA0; e1 = (sn == 1) ? 'hC16 : 'hB8; end
                    else if (ch == 1) begin en = 1; e0 = 'hB8; e1 = 0; end
                    else begin en = 0; e0 = 0; e1 = 0; end
                    run_chain(0, 0);
                    chk(pio_n == en, cap == 1 ? "R8 pio count" : "R9 pio count", pio_n, en);
                    if (en >= 1) chk(pio_log[0] == e0, cap == 1 ? "R8 first word" : "R9 chain word",
                                     pio_log[0], e0);
                    if (en == 2) chk(pio_log[1] == e1, "R8 branch target", pio_log[1], e1);
                    chk(xfer_n == 0, "R6 sense no xfer", xfer_n, 0);
                    chk(done_n == 1, "R7 sense list end", done_n, 1);
                end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule